// File: doc/BRIEF.md
# Two-Wire Bus Mode and Stuck-Line Supervisor

This block sits beside a two-wire serial target and follows the bus from already synchronized clock and data lines. It reports bus conditions as one-cycle pulses (start and stop), keeps a busy flag for the length of a transaction, and watches the first byte after each START. When that byte carries the high-speed controller code, the block raises a high-speed flag. The target's line filters use this flag to pick their fast timing, and the flag holds until the bus is released. While the code byte is being acknowledged, an inhibit output tells the target's responder to leave the acknowledge bit undriven.

A stuck-line timer runs only inside a transaction. It measures how long the lines go without both being high. When either line is held low past a parameterised number of system-clock cycles, the block emits a one-cycle interface-reset pulse. That pulse ends the transaction, drops the high-speed flag and releases the data line. After that the target ignores bus traffic until it sees a fresh START.

Top module: `tw_bus_supervisor`

## Requirements
- R1: A START (data sampled 1 then 0 while the clock is sampled 1 in both of two consecutive samples) gives a one-cycle `start_pulse` in the cycle after the sample that shows data low.
- R2: A STOP (data sampled 0 then 1 while the clock is sampled 1 in both samples) gives a one-cycle `stop_pulse` with the same latency, whether or not a transaction is open. A data change while the clock is low is neither START nor STOP.
- R3: `bus_busy` is set by START and cleared by STOP or by an interface reset. A repeated START keeps it set. If START and a clear fall in the same cycle, START wins.
- R4: Data is shifted MSB first on each clock rising edge. When the first byte after a START has its top five bits equal to 00001, `hs_mode` rises right after the eighth rising edge (for example bytes 0x08 and 0x0F).
- R5: `hs_mode` stays set through repeated STARTs and through later bytes, and it clears on STOP.
- R6: Only the first byte after a START is compared. A first byte such as 0x90 leaves `hs_mode` low, and a later byte of 0x0A does not set it.
- R7: `ack_inhibit` rises together with `hs_mode` when the controller code is recognized. It falls at the next START, STOP or interface reset, and it is never high while `hs_mode` is low.
- R8: Inside a transaction, once the lines have not both been high for `TMO_CYCLES` consecutive samples (counted from the sample after START), `if_reset` pulses for exactly one cycle. In that same cycle `bus_busy` and `hs_mode` are low.
- R9: Each sample with both lines high restarts the count. Outside a transaction nothing is counted, so a line held low on an idle bus never produces `if_reset`.
- R10: After an interface reset, clocked bytes are ignored until a new START. A 0x08 byte clocked in this state leaves `hs_mode` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line |
| start_pulse | output | 1 | One-cycle pulse on a START condition |
| stop_pulse | output | 1 | One-cycle pulse on a STOP condition |
| bus_busy | output | 1 | A transaction is open |
| hs_mode | output | 1 | High-speed filtering selected |
| ack_inhibit | output | 1 | Leave the acknowledge of the controller code undriven |
| if_reset | output | 1 | One-cycle serial-interface reset after a stuck line |

## Verification
The bench builds the block with `TMO_CYCLES` set to 40 instead of the multi-million default. At that value the exact firing cycle of the stuck-line timer can be counted step by step. It also becomes possible to show that a low phase of 35 cycles, cut short by both lines going high, does not fire. Bytes are clocked with two-cycle phases, so every byte-level check on the high-speed flag runs well inside that window, and the idle-bus test can hold the clock low for twice the threshold.

// File: rtl/tw_bus_pkg.sv
package tw_bus_pkg;

  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
  } bus_evt_t;

endpackage

// File: rtl/twbs_cond_detect.sv
module twbs_cond_detect
  import tw_bus_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt
);

  logic scl_q, sda_q;
  logic scl_d, sda_d;

  always_comb begin
    scl_d        = scl_i;
    sda_d        = sda_i;
    evt.start    = scl_q & scl_i & sda_q & ~sda_i;
    evt.stop     = scl_q & scl_i & ~sda_q & sda_i;
    evt.scl_rise = ~scl_q & scl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

endmodule

// File: rtl/twbs_first_byte.sv
module twbs_first_byte #(
  parameter int BYTE_W      = 8,
  parameter int PREFIX_W    = 5,
  parameter logic [PREFIX_W-1:0] PREFIX = 5'b00001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic busy,
  input  logic scl_rise,
  input  logic sda_i,
  output logic code_hit
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              armed_q, armed_d;
  logic [BYTE_W-1:0] shifted;
  logic              take_bit;

  always_comb begin
    shifted  = {shreg_q[BYTE_W-2:0], sda_i};
    take_bit = armed_q & busy & scl_rise & ~start_det;
    shreg_d  = shreg_q;
    cnt_d    = cnt_q;
    armed_d  = armed_q;
    code_hit = 1'b0;
    if (start_det) begin
      cnt_d   = '0;
      armed_d = 1'b1;
    end else if (!busy) begin
      armed_d = 1'b0;
    end else if (take_bit) begin
      shreg_d = shifted;
      if (cnt_q == LAST_BIT) begin
        armed_d  = 1'b0;
        code_hit = (shifted[BYTE_W-1 -: PREFIX_W] == PREFIX);
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

endmodule

// File: rtl/twbs_stuck_timer.sv
module twbs_stuck_timer #(
  parameter int TMO_CYCLES = 5_400_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic start_det,
  input  logic scl_i,
  input  logic sda_i,
  output logic expire
);

  localparam int CNT_W = $clog2(TMO_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TMO_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             idle_lines;
  logic             run;

  always_comb begin
    idle_lines = scl_i & sda_i;
    run        = busy & ~start_det & ~idle_lines;
    expire     = run & (cnt_q == LIMIT);
    if (!run || expire) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/tw_bus_supervisor.sv
module tw_bus_supervisor
  import tw_bus_pkg::*;
#(
  parameter int TMO_CYCLES = 5_400_000,
  parameter int BYTE_W     = 8,
  parameter int PREFIX_W   = 5,
  parameter logic [PREFIX_W-1:0] PREFIX = 5'b00001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_pulse,
  output logic stop_pulse,
  output logic bus_busy,
  output logic hs_mode,
  output logic ack_inhibit,
  output logic if_reset
);

  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] rst_sync_q;
  logic              rst_int_n;
  bus_evt_t          evt;
  logic              code_hit, expire;
  logic              busy_d, hs_d, inh_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_W-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_W-1];

  twbs_cond_detect u_cond (
    .clk   (clk),
    .rst_n (rst_int_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .evt   (evt)
  );

  twbs_first_byte #(
    .BYTE_W   (BYTE_W),
    .PREFIX_W (PREFIX_W),
    .PREFIX   (PREFIX)
  ) u_first (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_det (evt.start),
    .busy      (bus_busy),
    .scl_rise  (evt.scl_rise),
    .sda_i     (sda_i),
    .code_hit  (code_hit)
  );

  twbs_stuck_timer #(
    .TMO_CYCLES (TMO_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .busy      (bus_busy),
    .start_det (evt.start),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .expire    (expire)
  );

  always_comb begin
    busy_d = bus_busy;
    if (evt.stop || expire) busy_d = 1'b0;
    if (evt.start)          busy_d = 1'b1;

    hs_d = hs_mode;
    if (code_hit)           hs_d = 1'b1;
    if (evt.stop || expire) hs_d = 1'b0;

    inh_d = ack_inhibit;
    if (code_hit)                       inh_d = 1'b1;
    if (evt.start || evt.stop || expire) inh_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      start_pulse <= 1'b0;
      stop_pulse  <= 1'b0;
      bus_busy    <= 1'b0;
      hs_mode     <= 1'b0;
      ack_inhibit <= 1'b0;
      if_reset    <= 1'b0;
    end else begin
      start_pulse <= evt.start;
      stop_pulse  <= evt.stop;
      bus_busy    <= busy_d;
      hs_mode     <= hs_d;
      ack_inhibit <= inh_d;
      if_reset    <= expire;
    end
  end

endmodule

// File: rtl/tw_bus_supervisor_chk.sv
module tw_bus_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic start_pulse,
  input logic stop_pulse,
  input logic bus_busy,
  input logic hs_mode,
  input logic ack_inhibit,
  input logic if_reset
);

  // R1
  evt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_pulse, stop_pulse, if_reset}));

  // R1
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy) |-> start_pulse);

  // R3
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> !bus_busy);

  // R5
  hs_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_mode |-> bus_busy);

  // R7
  inhibit_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_inhibit |-> hs_mode);

  // R7
  inhibit_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode) |-> ack_inhibit);

  // R8
  reset_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if_reset |=> !if_reset);

  // R8
  reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    if_reset |-> (!bus_busy && !hs_mode));

endmodule

bind tw_bus_supervisor tw_bus_supervisor_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_pulse (start_pulse),
  .stop_pulse  (stop_pulse),
  .bus_busy    (bus_busy),
  .hs_mode     (hs_mode),
  .ack_inhibit (ack_inhibit),
  .if_reset    (if_reset)
);

// File: tb/test_tw_bus_supervisor.sv
`timescale 1ns/1ps
module test_tw_bus_supervisor;

  localparam int TMO = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic scl, sda;
  logic start_pulse, stop_pulse, bus_busy, hs_mode, ack_inhibit, if_reset;
  int   n_chk = 0;
  int   n_bad = 0;
  int   n_rst;

  always #2.5 clk = ~clk;

  tw_bus_supervisor #(.TMO_CYCLES(TMO)) i_tw_bus_supervisor (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse), .bus_busy(bus_busy),
    .hs_mode(hs_mode), .ack_inhibit(ack_inhibit), .if_reset(if_reset)
  );

  // {scl, sda, exp start, exp stop, exp busy}
  localparam logic [4:0] VEC [0:15] = '{
    5'b11000, 5'b10101, 5'b10001, 5'b00001,
    5'b01001, 5'b11001, 5'b10101, 5'b00001,
    5'b10001, 5'b11010, 5'b11000, 5'b01000,
    5'b00000, 5'b10000, 5'b11010, 5'b11000
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic d);
    @(negedge clk);
    scl = c;
    sda = d;
    @(posedge clk);
    #1;
  endtask

  task automatic do_start();
    step(0, 1); step(1, 1); step(1, 0); step(0, 0);
  endtask

  task automatic do_stop();
    step(0, 0); step(1, 0); step(1, 1); step(1, 1);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      step(0, b[i]); step(0, b[i]); step(1, b[i]); step(1, b[i]);
    end
    step(0, 1); step(0, 1); step(1, 1); step(1, 1); step(0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R3 reset busy", bus_busy, 0);
    chk("R8 reset if_reset", if_reset, 0);
    chk("R5 reset hs", hs_mode, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 R2 R3 table walk
    for (int k = 0; k < 16; k++) begin
      step(VEC[k][4], VEC[k][3]);
      chk($sformatf("R1 start vec%0d", k), start_pulse, VEC[k][2]);
      chk($sformatf("R2 stop vec%0d", k), stop_pulse, VEC[k][1]);
      chk($sformatf("R3 busy vec%0d", k), bus_busy, VEC[k][0]);
    end

    // R4 R5 R7: controller code, repeated start, further byte, stop
    do_start();
    send_byte(8'h08);
    chk("R4 hs after 0x08", hs_mode, 1);
    chk("R7 inhibit after code", ack_inhibit, 1);
    do_start();
    chk("R5 hs kept over restart", hs_mode, 1);
    chk("R7 inhibit cleared by start", ack_inhibit, 0);
    send_byte(8'h90);
    chk("R5 hs kept over byte", hs_mode, 1);
    do_stop();
    chk("R5 hs cleared by stop", hs_mode, 0);
    chk("R3 busy cleared by stop", bus_busy, 0);

    // R4 second code value
    do_start();
    send_byte(8'h0F);
    chk("R4 hs after 0x0F", hs_mode, 1);
    do_stop();

    // R6: non-matching first byte, matching-looking later byte
    do_start();
    send_byte(8'h90);
    chk("R6 hs after 0x90", hs_mode, 0);
    send_byte(8'h0A);
    chk("R6 hs after later 0x0A", hs_mode, 0);
    chk("R7 inhibit low", ack_inhibit, 0);
    do_stop();

    // R8: exact firing cycle
    step(1, 1); step(1, 1);
    step(1, 0);
    chk("R1 start before hold", start_pulse, 1);
    for (int k = 0; k < TMO - 1; k++) step(0, 0);
    chk("R8 no reset one early", if_reset, 0);
    step(0, 0);
    chk("R8 reset fires", if_reset, 1);
    chk("R8 busy cleared", bus_busy, 0);
    step(0, 0);
    chk("R8 reset single cycle", if_reset, 0);

    // R10: traffic ignored until new START
    send_byte(8'h08);
    chk("R10 hs ignored after reset", hs_mode, 0);
    chk("R10 busy stays low", bus_busy, 0);

    // R8 with hs active
    step(1, 1); step(1, 1);
    do_start();
    send_byte(8'h08);
    chk("R8 hs before stall", hs_mode, 1);
    n_rst = 0;
    for (int k = 0; k < TMO + 4; k++) begin
      step(0, 0);
      if (if_reset) n_rst++;
    end
    chk("R8 one reset pulse", n_rst, 1);
    chk("R8 hs cleared", hs_mode, 0);
    chk("R7 inhibit cleared by reset", ack_inhibit, 0);

    // R9: both-high sample restarts count
    step(1, 1); step(1, 1);
    do_start();
    n_rst = 0;
    for (int k = 0; k < TMO - 5; k++) begin
      step(0, 1);
      if (if_reset) n_rst++;
    end
    step(1, 1);
    for (int k = 0; k < TMO - 5; k++) begin
      step(0, 1);
      if (if_reset) n_rst++;
    end
    chk("R9 no reset with restart", n_rst, 0);
    chk("R9 busy kept", bus_busy, 1);
    do_stop();

    // R9: idle bus held low never counts
    n_rst = 0;
    for (int k = 0; k < 2 * TMO; k++) begin
      step(0, 1);
      if (if_reset) n_rst++;
    end
    chk("R9 idle no reset", n_rst, 0);
    step(1, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule